// File: doc/BRIEF.md
# Instruction Field Parser

This block splits a stream of instruction bytes into their fields. It takes one byte per cycle under a valid/ready handshake. It first takes in any operand-size (66H) and address-size (67H) override prefixes. It then captures the opcode byte. For opcodes that carry a register/memory specifier byte, it goes on to collect that byte, an optional scaled-index byte, a displacement of 0, 1, 2 or 4 bytes and any immediate data.

When the last byte of an instruction has been accepted, the block presents one record. The record holds the captured fields, the operand and address sizes in effect, and the total byte count. The record stays on the outputs until the consumer takes it, and no new byte is accepted during that time. A static input selects the default 16-bit or 32-bit mode. The supported opcodes are the register/memory moves (88H to 8BH), the register/memory adds (00H to 03H), the register/memory subtracts (28H to 2BH) and the immediate-to-memory moves (C6H, C7H).

Top module: `instr_field_parser`

## Requirements
- R1: The effective operand size is 32 bits when `def32_i` differs from whether a 66H prefix was seen. The effective address size follows the same rule with 67H. Two or more copies of a prefix act like one copy. Both prefix flags clear once a record has been taken.
- R2: The record reports the opcode byte, its bit 1 as the direction flag `rec_dir_o` and its bit 0 as the width flag `rec_wide_o`.
- R3: An opcode outside {00H-03H, 28H-2BH, 88H-8BH, C6H, C7H} ends the instruction at once. The record then has `rec_err_o`=1, no specifier byte, zero displacement and immediate lengths, and a length of the prefix count plus one.
- R4: For a supported opcode, the byte after the opcode is captured as the specifier. Its bits 7:6 are the mode field, bits 5:3 the register field and bits 2:0 the r/m field. A mode field of 11 gives no displacement and no scaled-index byte.
- R5: With 16-bit addressing, mode 00 gives no displacement, except that r/m 110 gives 2 bytes. Mode 01 gives 1 byte and mode 10 gives 2 bytes.
- R6: With 32-bit addressing, mode 01 gives 1 byte and mode 10 gives 4 bytes. Mode 00 gives 4 bytes when r/m is 101 and none otherwise, subject to R7.
- R7: With 32-bit addressing, a mode other than 11 and an r/m of 100 insert a scaled-index byte after the specifier. If that byte's bits 2:0 are 101 and the mode is 00, a 4-byte displacement follows.
- R8: Displacement and immediate bytes arrive least significant first. `rec_disp_o` is the displacement sign-extended from its own length to 32 bits, and `rec_imm_o` is the immediate zero-extended.
- R9: Opcode C6H carries a 1-byte immediate, and C7H carries a 2-byte or 4-byte immediate chosen by the effective operand size. The immediate follows the displacement. Other opcodes carry none.
- R10: `rec_len_o` counts every accepted byte of the instruction, prefixes included, and saturates at its all-ones value.
- R11: `in_ready_o` is low exactly while a record is pending. A pending record holds its values until `rec_ready_i` is high at a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| def32_i | input | 1 | Default mode, 1 = 32-bit; held constant within an instruction |
| in_byte_i | input | 8 | Instruction byte |
| in_valid_i | input | 1 | Byte offered |
| in_ready_o | output | 1 | Byte accepted this cycle when valid |
| rec_valid_o | output | 1 | Record pending |
| rec_ready_i | input | 1 | Consumer takes the record |
| rec_err_o | output | 1 | Unsupported opcode |
| rec_opcode_o | output | 8 | Opcode byte |
| rec_dir_o | output | 1 | Opcode bit 1 |
| rec_wide_o | output | 1 | Opcode bit 0 |
| rec_has_modrm_o | output | 1 | Specifier byte present |
| rec_modrm_o | output | 8 | Specifier byte |
| rec_has_sib_o | output | 1 | Scaled-index byte present |
| rec_sib_o | output | 8 | Scaled-index byte |
| rec_disp_len_o | output | 3 | Displacement bytes (0, 1, 2, 4) |
| rec_disp_o | output | 32 | Sign-extended displacement |
| rec_imm_len_o | output | 3 | Immediate bytes (0, 1, 2, 4) |
| rec_imm_o | output | 32 | Zero-extended immediate |
| rec_op32_o | output | 1 | Effective operand size is 32 bits |
| rec_addr32_o | output | 1 | Effective address size is 32 bits |
| rec_len_o | output | LEN_W | Instruction length in bytes |

## Verification
Some properties are checked on every cycle. A displacement length is legal for the address size in use. A scaled-index byte appears only under the r/m and mode conditions that call for it. Register-mode specifiers carry no displacement. Error records have the shape R3 requires. The immediate length of C7H follows the operand size. Prefix flags are empty after a record is taken. A pending record stays stable and stalls the input. The bench alone can show that each value is correct: that the displacement and immediate bytes land in the right place and are sign- or zero-extended correctly, and that lengths and sizes are right under every prefix combination and every specifier byte in both default modes.

// File: rtl/ifp_pkg.sv
package ifp_pkg;
  localparam int unsigned FIELD_B = 4;
  localparam int unsigned FIELD_W = 8 * FIELD_B;
  localparam int unsigned IDX_W   = $clog2(FIELD_B);

  typedef enum logic [2:0] {
    ST_HEAD  = 3'd0,
    ST_MODRM = 3'd1,
    ST_SIB   = 3'd2,
    ST_DISP  = 3'd3,
    ST_IMM   = 3'd4,
    ST_OUT   = 3'd5
  } ifp_state_e;

  localparam logic [7:0] PFX_OPSZ = 8'h66;
  localparam logic [7:0] PFX_ADSZ = 8'h67;
  localparam logic [7:0] OP_MOVI8 = 8'hC6;
  localparam logic [7:0] OP_MOVIW = 8'hC7;

  function automatic logic op_has_modrm(input logic [7:0] op);
    return (op[7:2] == 6'b100010) || (op[7:2] == 6'b000000) ||
           (op[7:2] == 6'b001010) || (op[7:1] == 7'b1100011);
  endfunction

  // state entered once the specifier (and scaled-index) byte is known
  function automatic ifp_state_e tail_state(input logic [2:0] disp_n,
                                            input logic [2:0] imm_n);
    if (disp_n != 3'd0)     return ST_DISP;
    else if (imm_n != 3'd0) return ST_IMM;
    else                    return ST_OUT;
  endfunction

  function automatic logic [FIELD_W-1:0] sext_field(input logic [FIELD_W-1:0] raw,
                                                    input logic [2:0] n);
    case (n)
      3'd1:    return {{(FIELD_W-8){raw[7]}}, raw[7:0]};
      3'd2:    return {{(FIELD_W-16){raw[15]}}, raw[15:0]};
      3'd4:    return raw;
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/ifp_prefix_reg.sv
module ifp_prefix_reg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hit_op_i,
  input  logic hit_ad_i,
  input  logic clr_i,
  output logic ovr_op_o,
  output logic ovr_ad_o
);
  logic op_q, ad_q;

  // set, not toggle: repeats are idempotent
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q <= 1'b0;
      ad_q <= 1'b0;
    end else if (clr_i) begin
      op_q <= 1'b0;
      ad_q <= 1'b0;
    end else begin
      if (hit_op_i) op_q <= 1'b1;
      if (hit_ad_i) ad_q <= 1'b1;
    end
  end

  assign ovr_op_o = op_q;
  assign ovr_ad_o = ad_q;

  AST_PFX_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (!ovr_op_o && !ovr_ad_o)); // R1
endmodule

// File: rtl/ifp_size_decode.sv
module ifp_size_decode (
  input  logic [7:0] op_i,
  input  logic [1:0] mod_i,
  input  logic [2:0] rm_i,
  input  logic       sib_seen_i,
  input  logic [2:0] sib_base_i,
  input  logic       addr32_i,
  input  logic       op32_i,
  output logic       need_sib_o,
  output logic [2:0] disp_n_o,
  output logic [2:0] imm_n_o
);
  logic reg_form;
  assign reg_form = (mod_i == 2'b11);

  assign need_sib_o = addr32_i && !reg_form && (rm_i == 3'b100);

  always_comb begin
    disp_n_o = 3'd0;
    if (!reg_form) begin
      if (!addr32_i) begin
        unique case (mod_i)
          2'b00:   disp_n_o = (rm_i == 3'b110) ? 3'd2 : 3'd0;
          2'b01:   disp_n_o = 3'd1;
          default: disp_n_o = 3'd2;
        endcase
      end else begin
        unique case (mod_i)
          2'b00: begin
            if (rm_i == 3'b101)                           disp_n_o = 3'd4;
            else if (sib_seen_i && sib_base_i == 3'b101)  disp_n_o = 3'd4;
            else                                          disp_n_o = 3'd0;
          end
          2'b01:   disp_n_o = 3'd1;
          default: disp_n_o = 3'd4;
        endcase
      end
    end
  end

  always_comb begin
    if (op_i == ifp_pkg::OP_MOVI8)      imm_n_o = 3'd1;
    else if (op_i == ifp_pkg::OP_MOVIW) imm_n_o = op32_i ? 3'd4 : 3'd2;
    else                                imm_n_o = 3'd0;
  end
endmodule

// File: rtl/ifp_le_field.sv
module ifp_le_field #(
  parameter int unsigned NB = 4,
  localparam int unsigned IW = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            ld_i,
  input  logic [IW-1:0]   idx_i,
  input  logic [7:0]      byte_i,
  output logic [8*NB-1:0] val_o
);
  logic [7:0] lane_q [NB];

  for (genvar g = 0; g < NB; g++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  lane_q[g] <= '0;
      else if (clr_i)                               lane_q[g] <= '0;
      else if (ld_i && idx_i == IW'(g))             lane_q[g] <= byte_i;
    end
    assign val_o[8*g +: 8] = lane_q[g];
  end
endmodule

// File: rtl/instr_field_parser.sv
module instr_field_parser
  import ifp_pkg::*;
#(
  parameter int unsigned LEN_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             def32_i,
  input  logic [7:0]       in_byte_i,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  output logic             rec_valid_o,
  input  logic             rec_ready_i,
  output logic             rec_err_o,
  output logic [7:0]       rec_opcode_o,
  output logic             rec_dir_o,
  output logic             rec_wide_o,
  output logic             rec_has_modrm_o,
  output logic [7:0]       rec_modrm_o,
  output logic             rec_has_sib_o,
  output logic [7:0]       rec_sib_o,
  output logic [2:0]       rec_disp_len_o,
  output logic [31:0]      rec_disp_o,
  output logic [2:0]       rec_imm_len_o,
  output logic [31:0]      rec_imm_o,
  output logic             rec_op32_o,
  output logic             rec_addr32_o,
  output logic [LEN_W-1:0] rec_len_o
);
  localparam logic [LEN_W-1:0] LEN_MAX = '1;

  ifp_state_e       st_q;
  logic [7:0]       opcode_q, modrm_q, sib_q;
  logic             err_q, has_modrm_q, has_sib_q;
  logic [2:0]       disp_n_q, imm_n_q;
  logic [IDX_W-1:0] cnt_q;
  logic [LEN_W-1:0] len_q;

  logic acc, pfx_op, pfx_ad, done;
  logic ovr_op, ovr_ad, op32, addr32;
  logic [7:0] modrm_v;
  logic dec_sib;
  logic [2:0] dec_disp, dec_imm;
  logic [FIELD_W-1:0] disp_raw, imm_raw;
  logic field_last;

  assign in_ready_o = (st_q != ST_OUT);
  assign acc        = in_valid_i && in_ready_o;
  assign pfx_op     = acc && (st_q == ST_HEAD) && (in_byte_i == PFX_OPSZ);
  assign pfx_ad     = acc && (st_q == ST_HEAD) && (in_byte_i == PFX_ADSZ);
  assign done       = (st_q == ST_OUT) && rec_ready_i;

  ifp_prefix_reg u_pfx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .hit_op_i (pfx_op),
    .hit_ad_i (pfx_ad),
    .clr_i    (done),
    .ovr_op_o (ovr_op),
    .ovr_ad_o (ovr_ad)
  );

  assign op32   = def32_i ^ ovr_op;
  assign addr32 = def32_i ^ ovr_ad;

  // decode sees the incoming byte in the state that captures it
  assign modrm_v = (st_q == ST_MODRM) ? in_byte_i : modrm_q;

  ifp_size_decode u_dec (
    .op_i       (opcode_q),
    .mod_i      (modrm_v[7:6]),
    .rm_i       (modrm_v[2:0]),
    .sib_seen_i (st_q == ST_SIB),
    .sib_base_i (in_byte_i[2:0]),
    .addr32_i   (addr32),
    .op32_i     (op32),
    .need_sib_o (dec_sib),
    .disp_n_o   (dec_disp),
    .imm_n_o    (dec_imm)
  );

  ifp_le_field #(.NB(FIELD_B)) u_disp (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (done),
    .ld_i   (acc && st_q == ST_DISP),
    .idx_i  (cnt_q),
    .byte_i (in_byte_i),
    .val_o  (disp_raw)
  );

  ifp_le_field #(.NB(FIELD_B)) u_imm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (done),
    .ld_i   (acc && st_q == ST_IMM),
    .idx_i  (cnt_q),
    .byte_i (in_byte_i),
    .val_o  (imm_raw)
  );

  always_comb begin
    field_last = 1'b0;
    if (st_q == ST_DISP) field_last = ((3'(cnt_q) + 3'd1) == disp_n_q);
    if (st_q == ST_IMM)  field_last = ((3'(cnt_q) + 3'd1) == imm_n_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_HEAD;
      opcode_q    <= '0;
      modrm_q     <= '0;
      sib_q       <= '0;
      err_q       <= 1'b0;
      has_modrm_q <= 1'b0;
      has_sib_q   <= 1'b0;
      disp_n_q    <= '0;
      imm_n_q     <= '0;
      cnt_q       <= '0;
    end else begin
      unique case (st_q)
        ST_HEAD: begin
          if (acc && !pfx_op && !pfx_ad) begin
            opcode_q <= in_byte_i;
            if (op_has_modrm(in_byte_i)) begin
              has_modrm_q <= 1'b1;
              st_q        <= ST_MODRM;
            end else begin
              err_q <= 1'b1;
              st_q  <= ST_OUT;
            end
          end
        end
        ST_MODRM: begin
          if (acc) begin
            modrm_q   <= in_byte_i;
            has_sib_q <= dec_sib;
            disp_n_q  <= dec_disp;
            imm_n_q   <= dec_imm;
            cnt_q     <= '0;
            st_q      <= dec_sib ? ST_SIB : tail_state(dec_disp, dec_imm);
          end
        end
        ST_SIB: begin
          if (acc) begin
            sib_q    <= in_byte_i;
            disp_n_q <= dec_disp;
            st_q     <= tail_state(dec_disp, imm_n_q);
          end
        end
        ST_DISP, ST_IMM: begin
          if (acc) begin
            if (field_last) begin
              cnt_q <= '0;
              st_q  <= (st_q == ST_DISP && imm_n_q != 3'd0) ? ST_IMM : ST_OUT;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        ST_OUT: begin
          if (rec_ready_i) begin
            st_q        <= ST_HEAD;
            opcode_q    <= '0;
            modrm_q     <= '0;
            sib_q       <= '0;
            err_q       <= 1'b0;
            has_modrm_q <= 1'b0;
            has_sib_q   <= 1'b0;
            disp_n_q    <= '0;
            imm_n_q     <= '0;
          end
        end
        default: st_q <= ST_HEAD;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     len_q <= '0;
    else if (done)                   len_q <= '0;
    else if (acc && len_q != LEN_MAX) len_q <= len_q + 1'b1;
  end

  assign rec_valid_o     = (st_q == ST_OUT);
  assign rec_err_o       = err_q;
  assign rec_opcode_o    = opcode_q;
  assign rec_dir_o       = opcode_q[1];
  assign rec_wide_o      = opcode_q[0];
  assign rec_has_modrm_o = has_modrm_q;
  assign rec_modrm_o     = modrm_q;
  assign rec_has_sib_o   = has_sib_q;
  assign rec_sib_o       = sib_q;
  assign rec_disp_len_o  = disp_n_q;
  assign rec_disp_o      = sext_field(disp_raw, disp_n_q);
  assign rec_imm_len_o   = imm_n_q;
  assign rec_imm_o       = imm_raw;
  assign rec_op32_o      = op32;
  assign rec_addr32_o    = addr32;
  assign rec_len_o       = len_q;

  AST_REC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rec_valid_o && !rec_ready_i) |=> (rec_valid_o && $stable(rec_len_o) && $stable(rec_disp_o))); // R11
  AST_STALL_IN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o |-> !in_ready_o); // R11
  AST_SIB_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rec_valid_o && rec_has_sib_o) |->
      (rec_addr32_o && rec_modrm_o[7:6] != 2'b11 && rec_modrm_o[2:0] == 3'b100)); // R7
  AST_DISP16_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rec_valid_o && !rec_addr32_o) |-> (rec_disp_len_o != 3'd4)); // R5
  AST_DISP32_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rec_valid_o && rec_addr32_o) |-> (rec_disp_len_o != 3'd2)); // R6
  AST_REG_NODISP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rec_valid_o && rec_has_modrm_o && rec_modrm_o[7:6] == 2'b11) |->
      (rec_disp_len_o == 3'd0 && !rec_has_sib_o)); // R4
  AST_ERR_SHAPE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rec_valid_o && rec_err_o) |->
      (!rec_has_modrm_o && rec_disp_len_o == 3'd0 && rec_imm_len_o == 3'd0)); // R3
  AST_IMM_WIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rec_valid_o && !rec_err_o && rec_opcode_o == OP_MOVIW) |->
      (rec_imm_len_o == (rec_op32_o ? 3'd4 : 3'd2))); // R9
endmodule

// File: tb/tb_instr_field_parser.sv
module tb_instr_field_parser;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        def32_i = 1'b0;
  logic [7:0]  in_byte_i = '0;
  logic        in_valid_i = 1'b0;
  logic        in_ready_o;
  logic        rec_valid_o;
  logic        rec_ready_i = 1'b0;
  logic        rec_err_o;
  logic [7:0]  rec_opcode_o;
  logic        rec_dir_o, rec_wide_o, rec_has_modrm_o, rec_has_sib_o;
  logic [7:0]  rec_modrm_o, rec_sib_o;
  logic [2:0]  rec_disp_len_o, rec_imm_len_o;
  logic [31:0] rec_disp_o, rec_imm_o;
  logic        rec_op32_o, rec_addr32_o;
  logic [3:0]  rec_len_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #2 clk_i = ~clk_i;

  instr_field_parser #(.LEN_W(4)) dut (.*);

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    in_valid_i = 1'b1;
    in_byte_i  = b;
    while (!in_ready_o) @(negedge clk_i);
    @(negedge clk_i);
    in_valid_i = 1'b0;
  endtask

  task automatic take_rec();
    rec_ready_i = 1'b1;
    @(negedge clk_i);
    rec_ready_i = 1'b0;
  endtask

  function automatic int e_disp_n(bit a32, logic [7:0] mr, logic [7:0] sb);
    logic [1:0] md = mr[7:6];
    logic [2:0] rm = mr[2:0];
    if (md == 2'd3) return 0;
    if (!a32) begin
      if (md == 2'd0) return (rm == 3'd6) ? 2 : 0;
      return (md == 2'd1) ? 1 : 2;
    end
    if (md == 2'd1) return 1;
    if (md == 2'd2) return 4;
    if (rm == 3'd5) return 4;
    if (rm == 3'd4 && sb[2:0] == 3'd5) return 4;
    return 0;
  endfunction

  task automatic run_one(input bit m32, input int n66, input int n67,
                         input logic [7:0] op, input logic [7:0] mr);
    bit sup, o32, a32, sib;
    int dn, im, ln;
    logic [7:0] sb;
    logic [7:0] db [4];
    logic [7:0] ib [4];
    logic [31:0] dv, iv;
    def32_i = m32;
    sup = (op[7:2] == 6'b100010) || (op[7:2] == 6'b000000) ||
          (op[7:2] == 6'b001010) || (op == 8'hC6) || (op == 8'hC7);
    o32 = m32 ^ (n66 > 0);
    a32 = m32 ^ (n67 > 0);
    sb  = {2'b10, 3'b001, mr[5:3]};
    sib = sup && a32 && mr[7:6] != 2'd3 && mr[2:0] == 3'd4;
    dn  = sup ? e_disp_n(a32, mr, sib ? sb : 8'h00) : 0;
    im  = !sup ? 0 : (op == 8'hC6) ? 1 : (op == 8'hC7) ? (o32 ? 4 : 2) : 0;
    db[0] = mr[0] ? 8'h85 : 8'h12; db[1] = mr[1] ? 8'hF4 : 8'h34;
    db[2] = 8'h9C; db[3] = 8'hA7;
    ib[0] = 8'hC1; ib[1] = 8'h22; ib[2] = 8'h33; ib[3] = 8'h84;
    ln = n66 + n67 + 1 + (sup ? 1 + (sib ? 1 : 0) + dn + im : 0);
    if (ln > 15) ln = 15;
    case (dn)
      1: dv = {{24{db[0][7]}}, db[0]};
      2: dv = {{16{db[1][7]}}, db[1], db[0]};
      4: dv = {db[3], db[2], db[1], db[0]};
      default: dv = 32'h0;
    endcase
    iv = 32'h0;
    for (int k = 0; k < im; k++) iv[8*k +: 8] = ib[k];

    for (int k = 0; k < n66; k++) send_byte(8'h66);
    for (int k = 0; k < n67; k++) send_byte(8'h67);
    send_byte(op);
    if (sup) begin
      send_byte(mr);
      if (sib) send_byte(sb);
      for (int k = 0; k < dn; k++) send_byte(db[k]);
      for (int k = 0; k < im; k++) send_byte(ib[k]);
    end
    chk("R11 record pending after last byte", 64'(rec_valid_o), 64'd1);
    chk("R1 op/addr size", {62'd0, rec_op32_o, rec_addr32_o}, {62'd0, o32, a32});
    chk("R2 opcode/dir/wide", {54'd0, rec_opcode_o, rec_dir_o, rec_wide_o},
        {54'd0, op, op[1], op[0]});
    chk("R10 length", 64'(rec_len_o), 64'(ln));
    if (!sup) begin
      chk("R3 error shape", {56'd0, rec_err_o, rec_has_modrm_o, rec_disp_len_o, rec_imm_len_o},
          {56'd0, 1'b1, 1'b0, 3'd0, 3'd0});
    end else begin
      chk("R4 specifier capture", {54'd0, rec_err_o, rec_has_modrm_o, rec_modrm_o},
          {54'd0, 1'b0, 1'b1, mr});
      chk("R7 scaled-index byte", {55'd0, rec_has_sib_o, sib ? rec_sib_o : 8'h00},
          {55'd0, sib, sib ? sb : 8'h00});
      if (a32) chk("R6 disp length 32-bit addr", 64'(rec_disp_len_o), 64'(dn));
      else     chk("R5 disp length 16-bit addr", 64'(rec_disp_len_o), 64'(dn));
      chk("R8 displacement value", 64'(rec_disp_o), 64'(dv));
      chk("R9 immediate length", 64'(rec_imm_len_o), 64'(im));
      chk("R8 immediate value", 64'(rec_imm_o), 64'(iv));
    end
    take_rec();
  endtask

  initial begin
    forever begin
      @(posedge clk_i);
      cyc++;
      if (cyc > 190000) begin
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    logic [7:0] ops [4];
    logic [3:0] held_len;
    ops[0] = 8'h8B; ops[1] = 8'hC7; ops[2] = 8'h00; ops[3] = 8'hC6;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R11 reset: no record", 64'(rec_valid_o), 64'd0);
    chk("R11 reset: ready", 64'(in_ready_o), 64'd1);

    // R1 R5 R6 R7 R8 R9 sweep over all specifier bytes
    for (int m = 0; m < 2; m++)
      for (int pc = 0; pc < 4; pc++)
        for (int o = 0; o < 4; o++)
          for (int mr = 0; mr < 256; mr++)
            run_one(m[0], (pc == 1) ? 1 : (pc == 3) ? 2 : 0,
                    (pc == 2) ? 1 : (pc == 3) ? 2 : 0, ops[o], mr[7:0]);

    // R3 unsupported opcodes, with and without prefixes
    run_one(1'b0, 0, 0, 8'h90, 8'h00);
    run_one(1'b1, 1, 0, 8'h8C, 8'h00);
    run_one(1'b0, 0, 1, 8'hF4, 8'h00);
    run_one(1'b1, 0, 0, 8'h04, 8'h00);
    // R10 saturation with many repeated prefixes
    run_one(1'b0, 16, 0, 8'h90, 8'h00);
    run_one(1'b1, 9, 9, 8'hC7, 8'h84);

    // R11 stall: a pending record holds and ignores offered bytes
    def32_i = 1'b0;
    send_byte(8'h8B);
    send_byte(8'hEC);
    held_len = rec_len_o;
    in_valid_i = 1'b1;
    in_byte_i  = 8'h66;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk_i);
      chk("R11 held valid", 64'(rec_valid_o), 64'd1);
      chk("R11 input stalled", 64'(in_ready_o), 64'd0);
      chk("R11 length stable", 64'(rec_len_o), 64'(held_len));
      chk("R11 modrm stable", 64'(rec_modrm_o), 64'hEC);
    end
    in_valid_i = 1'b0;
    take_rec();
    chk("R11 released", 64'(rec_valid_o), 64'd0);
    // offered 66H during stall must not have been taken as a prefix
    run_one(1'b0, 0, 0, 8'h89, 8'hC0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule